// File: doc/BRIEF.md
# AHB Slave Address Decoder with Boot Remap

This block is the slave-side decode and return path of a shared AHB fabric. During the address phase it takes the top four bits of the bus address and turns them into one of sixteen slave selects. Each slot therefore covers a 256 MB window. During the data phase that follows, it steers the read data, ready and response of the slave that was addressed back onto the shared master-side return bus.

A live remap input exchanges slots 0 and 1. Boot firmware can run from one memory at the bottom of the map and then relocate another memory there. The remap affects only decodes made in later address phases.

The slot is captured on each rising clock edge where the bus ready is high. That captured slot selects the return path for the whole data phase, however long the phase is stalled. When the captured transfer is idle or busy, the return bus reports ready and OKAY on its own, without any slave's help.

Top module: `ahb_slot_fabric`

## Requirements
- R1: Address bits [31:28] select the slot, and at all times after reset exactly one of the sixteen select lines is high.
- R2: With remap high, an address in slot 0 raises select 1 and an address in slot 1 raises select 0.
- R3: Remap has no effect on slots 2 to 15.
- R4: The slot is captured on a rising clock edge where the bus ready is high. Read data of the captured slave is returned during the following data phase.
- R5: In an active data phase the bus ready equals the captured slave's ready. The ready sent back to every slave equals the bus ready.
- R6: The captured slave's response code is forwarded unchanged. The codes are 00 OKAY, 01 ERROR, 10 RETRY and 11 SPLIT.
- R7: The data phase is idle after reset, and also when the transfer type at capture was IDLE (00) or BUSY (01). In an idle data phase the bus ready is high and the response is OKAY, whatever the slaves drive. NONSEQ (10) and SEQ (11) start active data phases.
- R8: While the bus ready is low, the captured slot is held. A new address on the bus does not re-steer the return path.
- R9: Toggling remap during a data phase does not re-steer the return path of that phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| remap_i | input | 1 | Exchanges slots 0 and 1 when high |
| haddr_i | input | 32 | Address-phase bus address |
| htrans_i | input | 2 | Address-phase transfer type |
| s_hrdata_i | input | 512 | Read data of the slaves, slave k in bits [32k+31:32k] |
| s_hready_i | input | 16 | Ready of each slave |
| s_hresp_i | input | 32 | Response of each slave, slave k in bits [2k+1:2k] |
| hsel_o | output | 16 | One-hot slave selects |
| hrdata_o | output | 32 | Read data to the masters |
| hready_o | output | 1 | Bus ready to the masters |
| hresp_o | output | 2 | Response to the masters |
| s_hreadyin_o | output | 1 | Bus ready echoed to all slaves |

## Verification
A wrong captured slot does not show during the address phase. It shows in the very next data phase, where the read data, ready and response of the wrong slave appear on the return bus. A capture made while the bus ready is low shows on the following edge: the data phase jumps to a different slave's data in the middle of a stall. A wrong active flag shows in the first idle phase, with a slave's ready or error code leaking through. A remap defect shows as soon as slot 0 or 1 is addressed, on the select lines of the same cycle.

// File: rtl/ahb_dec_pkg.sv
package ahb_dec_pkg;
  typedef enum logic [1:0] {
    RESP_OKAY  = 2'b00,
    RESP_ERROR = 2'b01,
    RESP_RETRY = 2'b10,
    RESP_SPLIT = 2'b11
  } resp_e;

  localparam logic [1:0] TRANS_IDLE   = 2'b00;
  localparam logic [1:0] TRANS_BUSY   = 2'b01;
  localparam logic [1:0] TRANS_NONSEQ = 2'b10;
  localparam logic [1:0] TRANS_SEQ    = 2'b11;
endpackage

// File: rtl/slot_decode.sv
module slot_decode #(
  parameter int ADDR_W    = 32,
  parameter int NUM_SLOTS = 16,
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 remap_i,
  output logic [SLOT_W-1:0]    slot_o,
  output logic [NUM_SLOTS-1:0] sel_o
);
  logic [SLOT_W-1:0] raw;
  assign raw = addr_i[ADDR_W-1 -: SLOT_W];

  // remap exchanges the two lowest slots only
  always_comb begin
    slot_o = raw;
    if (remap_i && (raw >> 1) == '0) slot_o = raw ^ SLOT_W'(1);
  end

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_sel
    assign sel_o[g] = (slot_o == SLOT_W'(g));
  end
endmodule

// File: rtl/dphase_track.sv
module dphase_track #(
  parameter int NUM_SLOTS = 16,
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hready_i,
  input  logic [1:0]        trans_i,
  input  logic [SLOT_W-1:0] slot_i,
  output logic [SLOT_W-1:0] slot_q_o,
  output logic              act_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q_o <= '0;
      act_q_o  <= 1'b0;
    end else if (hready_i) begin
      slot_q_o <= slot_i;
      act_q_o  <= trans_i[1];
    end
  end

  // R8
  hold_on_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hready_i |=> ($stable(slot_q_o) && $stable(act_q_o)));
endmodule

// File: rtl/resp_mux.sv
module resp_mux #(
  parameter int DATA_W    = 32,
  parameter int NUM_SLOTS = 16,
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic [SLOT_W-1:0]           slot_i,
  input  logic                        act_i,
  input  logic [NUM_SLOTS*DATA_W-1:0] s_hrdata_i,
  input  logic [NUM_SLOTS-1:0]        s_hready_i,
  input  logic [NUM_SLOTS*2-1:0]      s_hresp_i,
  output logic [DATA_W-1:0]           hrdata_o,
  output logic                        hready_o,
  output logic [1:0]                  hresp_o
);
  import ahb_dec_pkg::*;

  assign hrdata_o = s_hrdata_i[slot_i*DATA_W +: DATA_W];

  // idle data phase answers by itself
  always_comb begin
    if (act_i) begin
      hready_o = s_hready_i[slot_i];
      hresp_o  = s_hresp_i[slot_i*2 +: 2];
    end else begin
      hready_o = 1'b1;
      hresp_o  = RESP_OKAY;
    end
  end
endmodule

// File: rtl/ahb_slot_fabric.sv
module ahb_slot_fabric #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int NUM_SLOTS = 16,
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        remap_i,
  input  logic [ADDR_W-1:0]           haddr_i,
  input  logic [1:0]                  htrans_i,
  input  logic [NUM_SLOTS*DATA_W-1:0] s_hrdata_i,
  input  logic [NUM_SLOTS-1:0]        s_hready_i,
  input  logic [NUM_SLOTS*2-1:0]      s_hresp_i,
  output logic [NUM_SLOTS-1:0]        hsel_o,
  output logic [DATA_W-1:0]           hrdata_o,
  output logic                        hready_o,
  output logic [1:0]                  hresp_o,
  output logic                        s_hreadyin_o
);
  import ahb_dec_pkg::*;

  logic [SLOT_W-1:0] a_slot, d_slot;
  logic              d_act;

  slot_decode #(.ADDR_W(ADDR_W), .NUM_SLOTS(NUM_SLOTS)) u_dec (
    .addr_i (haddr_i),
    .remap_i(remap_i),
    .slot_o (a_slot),
    .sel_o  (hsel_o)
  );

  dphase_track #(.NUM_SLOTS(NUM_SLOTS)) u_trk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hready_i(hready_o),
    .trans_i (htrans_i),
    .slot_i  (a_slot),
    .slot_q_o(d_slot),
    .act_q_o (d_act)
  );

  resp_mux #(.DATA_W(DATA_W), .NUM_SLOTS(NUM_SLOTS)) u_mux (
    .slot_i    (d_slot),
    .act_i     (d_act),
    .s_hrdata_i(s_hrdata_i),
    .s_hready_i(s_hready_i),
    .s_hresp_i (s_hresp_i),
    .hrdata_o  (hrdata_o),
    .hready_o  (hready_o),
    .hresp_o   (hresp_o)
  );

  assign s_hreadyin_o = hready_o;

  // R1
  one_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(hsel_o) == 1);

  // R2
  remap_swap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (remap_i && haddr_i[ADDR_W-1 -: SLOT_W] == '0) |-> hsel_o[1]);

  // R7
  idle_okay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hready_o && !htrans_i[1]) |=> (hready_o && hresp_o == RESP_OKAY));
endmodule

// File: tb/sim_ahb_slot_fabric.sv
module sim_ahb_slot_fabric;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 16;

  logic          clk = 0, rst_ni = 0, remap = 0;
  logic [31:0]   haddr = '0;
  logic [1:0]    htrans = 2'b00;
  logic [NS*32-1:0] s_hrdata;
  logic [NS-1:0] rdy_v = '1;
  logic [NS*2-1:0] resp_v = '0;
  logic [NS-1:0] hsel;
  logic [31:0]   hrdata;
  logic          hready, hreadyin;
  logic [1:0]    hresp;
  int n_run = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] sdat(int k);
    return 32'h5A00_0000 + k * 32'h0101_0011;
  endfunction

  always_comb for (int k = 0; k < NS; k++) s_hrdata[k*32 +: 32] = sdat(k);

  ahb_slot_fabric u0 (
    .clk_i(clk), .rst_ni(rst_ni), .remap_i(remap), .haddr_i(haddr),
    .htrans_i(htrans), .s_hrdata_i(s_hrdata), .s_hready_i(rdy_v),
    .s_hresp_i(resp_v), .hsel_o(hsel), .hrdata_o(hrdata),
    .hready_o(hready), .hresp_o(hresp), .s_hreadyin_o(hreadyin)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic edge_step();
    @(posedge clk); #1;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_fail++; n_run++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rdy_v = '0;
    resp_v = {NS{2'b01}};
    repeat (2) @(posedge clk);
    #2 rst_ni = 1; #1;
    // R7 reset state
    chk(hready === 1'b1, "R7 reset ready", 32'(hready), 1);
    chk(hresp === 2'b00, "R7 reset resp", 32'(hresp), 0);
    rdy_v = '1;

    for (int r = 0; r < 2; r++) begin
      for (int s = 0; s < NS; s++) begin
        int exp_k;
        remap = r[0];
        for (int k = 0; k < NS; k++) resp_v[k*2 +: 2] = 2'((k + r + s) % 4);
        haddr = {4'(s), 28'(s * 28'h0012345 + r)};
        htrans = (s % 2) ? 2'b11 : 2'b10;
        exp_k = (r == 1 && s < 2) ? (s ^ 1) : s;
        #1;
        // R1 R2 R3
        chk(hsel === 16'(1 << exp_k), (s < 2) ? "R2 remap select" : "R1 R3 select",
            32'(hsel), 32'(1 << exp_k));
        edge_step();
        htrans = 2'b00; haddr = 32'hF000_0000; #1;
        // R4
        chk(hrdata === sdat(exp_k), "R4 read data", hrdata, sdat(exp_k));
        // R6
        chk(hresp === 2'((exp_k + r + s) % 4), "R6 response", 32'(hresp), 32'((exp_k + r + s) % 4));
        // R5
        rdy_v[exp_k] = 1'b0; #1;
        chk(hready === 1'b0 && hreadyin === 1'b0, "R5 ready low", 32'({hready, hreadyin}), 0);
        rdy_v[exp_k] = 1'b1; #1;
        chk(hready === 1'b1 && hreadyin === 1'b1, "R5 ready high", 32'({hready, hreadyin}), 3);
        edge_step();
      end
    end

    // R7 idle data phase ignores slaves
    remap = 0; rdy_v = '0; resp_v = {NS{2'b01}}; #1;
    chk(hready === 1'b1, "R7 idle ready", 32'(hready), 1);
    chk(hresp === 2'b00, "R7 idle resp", 32'(hresp), 0);
    rdy_v = '1;
    // R7 BUSY captured is idle too
    haddr = 32'h3000_0000; htrans = 2'b01; edge_step();
    htrans = 2'b00; rdy_v[3] = 0; resp_v[6 +: 2] = 2'b11; #1;
    chk(hready === 1'b1 && hresp === 2'b00, "R7 busy phase", 32'({hready, hresp}), 32'h4);
    rdy_v = '1; resp_v = '0;

    // R8 stall holds captured slot
    haddr = 32'h5000_0000; htrans = 2'b10; edge_step();
    rdy_v[5] = 0; haddr = 32'h9000_0000; htrans = 2'b10; #1;
    chk(hready === 1'b0, "R8 stall ready", 32'(hready), 0);
    edge_step();
    chk(hrdata === sdat(5), "R8 held slot", hrdata, sdat(5));
    chk(hsel === 16'(1 << 9), "R8 new select", 32'(hsel), 32'(1 << 9));
    rdy_v[5] = 1; edge_step();
    htrans = 2'b00; #1;
    chk(hrdata === sdat(9), "R8 next phase", hrdata, sdat(9));
    edge_step();

    // R9 remap toggle mid data phase
    remap = 0; haddr = 32'h0000_0040; htrans = 2'b10; edge_step();
    htrans = 2'b00; rdy_v[0] = 0; remap = 1; edge_step();
    chk(hrdata === sdat(0), "R9 no re-steer", hrdata, sdat(0));
    chk(hready === 1'b0, "R9 ready of slot 0", 32'(hready), 0);
    rdy_v[0] = 1; edge_step();
    haddr = 32'h0000_0040; htrans = 2'b10; edge_step();
    htrans = 2'b00; #1;
    chk(hrdata === sdat(1), "R9 later decode", hrdata, sdat(1));

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule